// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K words by 8 bits. The host issues a request with an address, a write flag and write data. It may do so only while `ready_o` is high. The controller then runs one complete RAM cycle. It drives the 17-bit RAM address and the three active-low strobes: chip select, output enable and write enable. It also decides when its own data-pad driver is switched on. A read ends with a one-cycle `rvalid_o` pulse that carries the byte sampled from the RAM.

Every interval is a parameter counted in system clock cycles, rounded up from the RAM's nanosecond limits. These intervals are the read access, the address setup before the write strobe, the write pulse, the wait before driving data after the write strobe falls, the recovery after the write, and the bus turnaround. The defaults suit a 10 ns part and a 100 MHz clock. When a read follows a write, or a write follows a read, turnaround cycles are inserted. During these cycles all strobes are high and the bus is released.

The data bus is brought out as separate input, output and output-enable pins, so the pad ring owns the tri-state buffer.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and in idle, chip select, output enable and write enable are all high (inactive), `ram_dq_oe_o` is 0 and `ready_o` is 1. Whenever chip select is high, the other two strobes are high and `ram_dq_oe_o` is 0.
- R2: A request is taken only on a clock edge where `req_i` and `ready_o` are both 1. `ready_o` is 0 from the cycle after acceptance until the RAM cycle ends, and a request raised while `ready_o` is 0 has no effect.
- R3: A read drives chip select and output enable low, with write enable high, and ends with `rvalid_o` = 1 for exactly one cycle. That pulse comes RD_CYC+1 clock edges after the accepting edge, plus TA_CYC when turnaround is inserted.
- R4: A write holds write enable low for exactly WR_CYC consecutive cycles. Output enable stays high for the whole write, and output enable and write enable are never low together.
- R5: During a write, `ram_dq_oe_o` rises WHZ_CYC cycles after write enable falls. It is still high in the cycle in which write enable rises, so the write data is valid when the write ends.
- R6: `ram_addr_o` does not change while chip select is low.
- R7: `ram_dq_oe_o` is never 1 while output enable is low, so the RAM and the controller never drive the bus at once.
- R8: Turnaround applies when an operation's direction differs from the previous accepted one. TA_CYC cycles are then inserted between acceptance and chip select falling, with all strobes high and the bus released. Otherwise chip select falls in the cycle right after acceptance.
- R9: A read returns the byte most recently written to that address, and 0 for an address never written. Addresses 0 and 17'h1FFFF behave like any other address.
- R10: `rvalid_o` is never high in two consecutive cycles, and it is never high except at the end of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Host word address |
| wdata_i | input | 8 | Host write data |
| ready_o | output | 1 | Controller can take a request |
| rvalid_o | output | 1 | One-cycle read data valid |
| rdata_o | output | 8 | Read data |
| ram_addr_o | output | 17 | RAM address |
| ram_ce_no | output | 1 | RAM chip select, active low |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_we_no | output | 1 | RAM write enable, active low |
| ram_dq_o | output | 8 | Data toward the RAM |
| ram_dq_oe_o | output | 1 | Enable of the controller's data pad driver |
| ram_dq_i | input | 8 | Data from the RAM |

## Verification
The bench records the cycle count at the edge that accepts each request. For a read, it queues the expected byte together with the cycle in which `rvalid_o` is due: RD_CYC+1 edges later, plus TA_CYC across a direction change. The monitor compares both the byte and that exact cycle when the pulse appears. For every operation, the driver counts the cycles from acceptance until chip select falls and expects 1, or 1+TA_CYC after a direction change. The write monitor measures the write-enable low run against WR_CYC and the first driven cycle against WHZ_CYC+1. A behavioural RAM model counts address changes during a write, bus contention and writes that end without driven data. All observations are taken on falling clock edges, half a cycle after the registered outputs settle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_SAMPLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURN
  } state_e;
endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC    = 1,
  parameter int SETUP_CYC = 1,
  parameter int WR_CYC    = 2,
  parameter int REC_CYC   = 1,
  parameter int TA_CYC    = 1,
  parameter int WHZ_CYC   = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   accept_i,
  input  logic   we_i,
  output state_e st_q_o,
  output state_e st_d_o,
  output logic   drive_d_o,
  output logic   sample_o
);
  localparam int M1   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int M2   = (SETUP_CYC > REC_CYC) ? SETUP_CYC : REC_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > TA_CYC) ? M3 : TA_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  state_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          op_we_q, last_we_q, have_prev_q;
  logic          done;

  function automatic logic [CW-1:0] len_of(state_e s);
    case (s)
      ST_RD_ACCESS:  return CW'(RD_CYC);
      ST_WR_SETUP:   return CW'(SETUP_CYC);
      ST_WR_PULSE:   return CW'(WR_CYC);
      ST_WR_RECOVER: return CW'(REC_CYC);
      ST_TURN:       return CW'(TA_CYC);
      default:       return CW'(1);
    endcase
  endfunction

  assign done = (cnt_q == len_of(st_q) - 1'b1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept_i) begin
          if (have_prev_q && (last_we_q != we_i)) st_d = ST_TURN;
          else st_d = we_i ? ST_WR_SETUP : ST_RD_ACCESS;
        end
      end
      ST_TURN:       if (done) st_d = op_we_q ? ST_WR_SETUP : ST_RD_ACCESS;
      ST_RD_ACCESS:  if (done) st_d = ST_RD_SAMPLE;
      ST_RD_SAMPLE:  if (done) st_d = ST_IDLE;
      ST_WR_SETUP:   if (done) st_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (done) st_d = ST_WR_RECOVER;
      ST_WR_RECOVER: if (done) st_d = ST_IDLE;
      default:       st_d = ST_IDLE;
    endcase
    if (st_q != ST_IDLE && done) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      op_we_q     <= 1'b0;
      last_we_q   <= 1'b0;
      have_prev_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (accept_i) begin
        op_we_q     <= we_i;
        last_we_q   <= we_i;
        have_prev_q <= 1'b1;
      end
    end
  end

  // drive only after the RAM outputs have had WHZ_CYC cycles to turn off
  assign drive_d_o = ((st_d == ST_WR_PULSE) && (cnt_d >= CW'(WHZ_CYC))) ||
                     (st_d == ST_WR_RECOVER);
  assign sample_o  = (st_q == ST_RD_SAMPLE) && done;
  assign st_q_o    = st_q;
  assign st_d_o    = st_d;
endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  state_e        st_d_i,
  input  logic          drive_d_i,
  input  logic          sample_i,
  input  logic [DW-1:0] ram_dq_i,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_ce_no,
  output logic          ram_oe_no,
  output logic          ram_we_no,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  logic ce_n_d, oe_n_d, we_n_d;

  // strobes decoded from next state and registered: glitch-free pins
  assign ce_n_d = (st_d_i == ST_IDLE) || (st_d_i == ST_TURN);
  assign oe_n_d = !((st_d_i == ST_RD_ACCESS) || (st_d_i == ST_RD_SAMPLE));
  assign we_n_d = (st_d_i != ST_WR_PULSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_ce_no   <= 1'b1;
      ram_oe_no   <= 1'b1;
      ram_we_no   <= 1'b1;
      ram_dq_oe_o <= 1'b0;
      ram_addr_o  <= '0;
      ram_dq_o    <= '0;
      rvalid_o    <= 1'b0;
      rdata_o     <= '0;
    end else begin
      ram_ce_no   <= ce_n_d;
      ram_oe_no   <= oe_n_d;
      ram_we_no   <= we_n_d;
      ram_dq_oe_o <= drive_d_i;
      rvalid_o    <= sample_i;
      if (accept_i) begin
        ram_addr_o <= addr_i;
        ram_dq_o   <= wdata_i;
      end
      if (sample_i) rdata_o <= ram_dq_i;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int RD_CYC    = 1,
  parameter int SETUP_CYC = 1,
  parameter int WR_CYC    = 2,
  parameter int REC_CYC   = 1,
  parameter int TA_CYC    = 1,
  parameter int WHZ_CYC   = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_ce_no,
  output logic          ram_oe_no,
  output logic          ram_we_no,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe_o,
  input  logic [DW-1:0] ram_dq_i
);
  state_e st_q, st_d;
  logic   accept, drive_d, sample;

  assign ready_o = (st_q == ST_IDLE);
  assign accept  = req_i && ready_o;

  sram_ctrl_seq #(
    .RD_CYC(RD_CYC), .SETUP_CYC(SETUP_CYC), .WR_CYC(WR_CYC),
    .REC_CYC(REC_CYC), .TA_CYC(TA_CYC), .WHZ_CYC(WHZ_CYC)
  ) i_seq (
    .clk_i, .rst_ni,
    .accept_i (accept),
    .we_i,
    .st_q_o   (st_q),
    .st_d_o   (st_d),
    .drive_d_o(drive_d),
    .sample_o (sample)
  );

  sram_ctrl_pins #(.AW(AW), .DW(DW)) i_pins (
    .clk_i, .rst_ni,
    .accept_i  (accept),
    .addr_i, .wdata_i,
    .st_d_i    (st_d),
    .drive_d_i (drive_d),
    .sample_i  (sample),
    .ram_dq_i,
    .ram_addr_o, .ram_ce_no, .ram_oe_no, .ram_we_no,
    .ram_dq_o, .ram_dq_oe_o,
    .rvalid_o, .rdata_o
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic [AW-1:0] ram_addr_o,
  input logic          ram_ce_no,
  input logic          ram_oe_no,
  input logic          ram_we_no,
  input logic          ram_dq_oe_o
);
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_ce_no |-> (ram_oe_no && ram_we_no && !ram_dq_oe_o)); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o); // R2
  AST_NO_OE_WITH_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ram_oe_no && !ram_we_no)); // R4
  AST_NO_DRIVE_AT_WE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_we_no) |-> !ram_dq_oe_o); // R5
  AST_DATA_AT_WE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_no) |-> ram_dq_oe_o); // R5
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_ce_no && !$past(ram_ce_no)) |-> (ram_addr_o == $past(ram_addr_o))); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_no |-> !ram_dq_oe_o); // R7
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R10
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW)) i_sram_ctrl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ready_o(ready_o),
  .rvalid_o(rvalid_o), .ram_addr_o(ram_addr_o), .ram_ce_no(ram_ce_no),
  .ram_oe_no(ram_oe_no), .ram_we_no(ram_we_no), .ram_dq_oe_o(ram_dq_oe_o)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
  localparam int RD = 1, SU = 1, WR = 2, REC = 1, TA = 1, WHZ = 1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [16:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o, rvalid_o, ram_ce_no, ram_oe_no, ram_we_no, ram_dq_oe_o;
  logic [7:0]  rdata_o, ram_dq_o;
  logic [7:0]  ram_dq_i = 8'hxx;
  logic [16:0] ram_addr_o;

  always #4 clk = ~clk;

  sram_ctrl #(.RD_CYC(RD), .SETUP_CYC(SU), .WR_CYC(WR), .REC_CYC(REC),
              .TA_CYC(TA), .WHZ_CYC(WHZ)) i_sram_ctrl (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .ready_o,
    .rvalid_o, .rdata_o, .ram_addr_o, .ram_ce_no, .ram_oe_no, .ram_we_no,
    .ram_dq_o, .ram_dq_oe_o, .ram_dq_i);

  typedef struct {logic [7:0] data; int due;} exp_t;
  exp_t       sbq[$];
  logic [7:0] ref_mem[int];
  logic [7:0] mdl_mem[int];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit have_prev = 0, last_w = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural RAM model
  int viol_addr = 0, viol_cont = 0, viol_setup = 0;
  bit in_wr = 0, wr_drv = 0;
  logic [16:0] wr_addr;
  logic [7:0]  wr_dat;
  always @(negedge clk) begin
    if (!ram_ce_no && !ram_we_no) begin
      if (!in_wr) begin in_wr = 1; wr_addr = ram_addr_o; end
      else if (ram_addr_o != wr_addr) viol_addr++;
      wr_drv = ram_dq_oe_o;
      wr_dat = ram_dq_oe_o ? ram_dq_o : 8'hxx;
    end else if (in_wr) begin
      in_wr = 0;
      if (!wr_drv) viol_setup++;
      mdl_mem[int'(wr_addr)] = wr_dat;
    end
    if (!ram_ce_no && !ram_oe_no && ram_we_no) begin
      if (ram_dq_oe_o) viol_cont++;
      ram_dq_i = mdl_mem.exists(int'(ram_addr_o)) ? mdl_mem[int'(ram_addr_o)] : 8'h00;
    end else ram_dq_i = 8'hxx;
  end

  // write strobe monitor
  int we_run = 0, first_drv = 0;
  always @(negedge clk) if (rst_ni) begin
    if (!ram_we_no) begin
      we_run++;
      if (ram_dq_oe_o && first_drv == 0) first_drv = we_run;
      chk(ram_oe_no, "R4 oe high during write", ram_oe_no, 1);
    end else if (we_run > 0) begin
      chk(we_run == WR, "R4 write pulse length", we_run, WR);
      chk(first_drv == WHZ + 1, "R5 drive delay after we fall", first_drv, WHZ + 1);
      chk(ram_dq_oe_o, "R5 data held at we rise", ram_dq_oe_o, 1);
      we_run = 0; first_drv = 0;
    end
  end

  // read monitor / scoreboard
  exp_t e_pop;
  always @(negedge clk) if (rst_ni && rvalid_o) begin
    if (sbq.size() == 0) chk(0, "R10 unexpected rvalid", 1, 0);
    else begin
      e_pop = sbq.pop_front();
      chk(rdata_o == e_pop.data, "R9 read data", rdata_o, e_pop.data);
      chk(cyc == e_pop.due, "R3 read latency", cyc, e_pop.due);
    end
  end

  task automatic do_op(input bit w, input logic [16:0] a, input logic [7:0] d);
    int ta, k;
    exp_t e;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    ta = (have_prev && last_w != w) ? TA : 0;
    req_i = 1; we_i = w; addr_i = a; wdata_i = d;
    if (!w) begin
      e.data = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
      e.due  = cyc + 2 + ta + RD;
      sbq.push_back(e);
    end else ref_mem[int'(a)] = d;
    have_prev = 1; last_w = w;
    @(negedge clk);
    req_i = 0;
    chk(!ready_o, "R2 ready low after accept", ready_o, 0);
    k = 1;
    while (ram_ce_no) begin
      chk(ram_oe_no && ram_we_no && !ram_dq_oe_o, "R8 bus released in turnaround",
          {ram_oe_no, ram_we_no, ram_dq_oe_o}, 3'b110);
      @(negedge clk);
      k++;
    end
    chk(k == 1 + ta, "R8 cycles to chip select", k, 1 + ta);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ram_ce_no && ram_oe_no && ram_we_no, "R1 strobes high in reset",
        {ram_ce_no, ram_oe_no, ram_we_no}, 3'b111);
    chk(!ram_dq_oe_o, "R1 bus released in reset", ram_dq_oe_o, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(ready_o && ram_ce_no && !rvalid_o, "R1 idle after reset",
        {ready_o, ram_ce_no, rvalid_o}, 3'b110);
    // directed
    do_op(0, 17'h00123, 8'h00);           // R9 unwritten reads 0
    do_op(0, 17'h00124, 8'h00);           // R3 no turnaround read-read
    do_op(1, 17'h00000, 8'hA5);           // R8 turnaround read->write
    do_op(1, 17'h1FFFF, 8'h5A);           // R9 top address
    // R2: request raised while busy is ignored
    req_i = 1; we_i = 1; addr_i = 17'h00000; wdata_i = 8'hEE;
    @(negedge clk);
    chk(!ready_o, "R2 busy while poking", ready_o, 0);
    req_i = 0;
    do_op(0, 17'h00000, 8'h00);           // R9 expects A5, not EE
    do_op(0, 17'h1FFFF, 8'h00);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [16:0] a;
      a = ($urandom % 2) ? 17'(16'h0100 + ($urandom % 8)) : 17'($urandom);
      do_op(1'($urandom % 2), a, 8'($urandom));
    end
    repeat (10) @(negedge clk);
    chk(sbq.size() == 0, "R3 all reads returned", sbq.size(), 0);
    chk(viol_addr == 0, "R6 address stable during write", viol_addr, 0);
    chk(viol_cont == 0, "R7 no bus contention", viol_cont, 0);
    chk(viol_setup == 0, "R5 data driven at end of write", viol_setup, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule